// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block sits between a bank of interrupt request lines and a processor core. Each request line can be enabled, forced active by software, and steered to one of two classes: a fast class, which drives the fast interrupt output, or a normal class, which drives the normal interrupt output. Normal requests are ranked through a set of programmable vector slots. Each slot binds one source number to a handler address. Sources that no enabled slot claims share one default handler address.

Software reads the vector-address register to get the handler of the most urgent pending normal request. That read also marks the request's priority level as in service. While a level is in service, requests of that level and of every lower level are held off. A request of higher priority can still nest on top of it. Each write to the vector-address register retires the most recently entered (highest-priority) level. Fast-class requests never pass through this nesting logic.

Register access uses a simple word-addressed bus with one-cycle write and read strobes. Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

Top module: `vic_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the enables, forces, class selects, slot enables, slot source fields, the default address and the in-service state. While reset is applied, and in the first cycle after it, `irq_o` and `fiq_o` are low.
- R2: The raw status register at word address 0x02 reads `src_i | force`. The force bits are set by writing ones to address 0x06 and cleared by writing ones to address 0x07. Reading address 0x06 returns the force bits. Zero bits in a set or clear write leave the matching force bits unchanged.
- R3: The enable bits are set by writing ones to address 0x04 and cleared by writing ones to address 0x05. Reading 0x04 returns the enables. The class register at 0x03 holds the class selects, where 1 means fast class. The normal-class status at 0x00 reads raw & enable & ~class. The fast-class status at 0x01 reads raw & enable & class.
- R4: `fiq_o` equals the OR of the fast-class status one cycle earlier, whatever the in-service state.
- R5: Slot n has a control word at address 0x10+n and a handler address at 0x20+n. In the control word, bit 8 is the slot enable and the low log2(NSRC) bits are the source number. Both read back what was written.
- R6: A read of address 0x08 returns the handler address of the lowest-numbered enabled slot that is not blocked and whose source is pending in the normal-class status.
- R7: If no slot qualifies but a normal-class source claimed by no enabled slot is pending, a read of 0x08 returns the default address, which is held at address 0x09. If nothing is eligible, the read returns the default address and changes no in-service state.
- R8: A qualifying read of 0x08 marks that slot's level as in service. A slot is blocked while its own level or any lower-numbered level is in service. `irq_o` is high one cycle after any unblocked normal request is pending.
- R9: A higher-priority slot can be read, and so marked in service, while a lower-priority slot is still in service. Each write to 0x08 retires only the lowest-numbered level in service.
- R10: The default vector occupies the lowest level, below slot NSLOT-1. A non-vectored request is eligible only when no level at all is in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Interrupt request lines, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (ignored when bus_wr is high) |
| bus_addr | input | 6 | Register word address |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid the cycle after bus_rd |
| irq_o | output | 1 | Normal interrupt request to the core |
| fiq_o | output | 1 | Fast interrupt request to the core |

## Verification
The bench builds the controller with NSRC=8, NSLOT=4 and DW=32. At this size every source can be forced and vectored one at a time, and it can be checked against both claimed and unclaimed slots. Every slot level, plus the default level, can be stacked in service in a single nesting sequence. Enable, class and line patterns are generated arithmetically over the 8-bit space, so the status masks and the fast output are checked under many distinct mixes of the two classes.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int REG_AW = 6;
  typedef logic [REG_AW-1:0] reg_addr_t;

  // word addresses; the vector register at 0x08 carries side effects
  localparam reg_addr_t A_IRQ_STAT = 6'h00;
  localparam reg_addr_t A_FIQ_STAT = 6'h01;
  localparam reg_addr_t A_RAW_STAT = 6'h02;
  localparam reg_addr_t A_CLASS    = 6'h03;
  localparam reg_addr_t A_EN_SET   = 6'h04;
  localparam reg_addr_t A_EN_CLR   = 6'h05;
  localparam reg_addr_t A_FRC_SET  = 6'h06;
  localparam reg_addr_t A_FRC_CLR  = 6'h07;
  localparam reg_addr_t A_VEC      = 6'h08;
  localparam reg_addr_t A_DEF      = 6'h09;

  // region selectors in bus_addr[5:4]
  localparam logic [1:0] RG_SLOT_CTL = 2'b01;
  localparam logic [1:0] RG_SLOT_ADR = 2'b10;

  localparam int CTL_EN_BIT = 8;
endpackage

// File: rtl/vic_src.sv
module vic_src #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic [NSRC-1:0] wdata,
  input  logic            en_set,
  input  logic            en_clr,
  input  logic            frc_set,
  input  logic            frc_clr,
  input  logic            cls_we,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] frc_q,
  output logic [NSRC-1:0] cls_q,
  output logic [NSRC-1:0] raw,
  output logic [NSRC-1:0] irq_stat,
  output logic [NSRC-1:0] fiq_stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= '0;
      frc_q <= '0;
      cls_q <= '0;
    end else begin
      if (en_set)       en_q  <= en_q | wdata;
      else if (en_clr)  en_q  <= en_q & ~wdata;
      if (frc_set)      frc_q <= frc_q | wdata;
      else if (frc_clr) frc_q <= frc_q & ~wdata;
      if (cls_we)       cls_q <= wdata;
    end
  end

  always_comb begin
    raw      = src_i | frc_q;
    irq_stat = raw & en_q & ~cls_q;
    fiq_stat = raw & en_q & cls_q;
  end
endmodule

// File: rtl/vic_slots.sv
module vic_slots
  import vic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSRC-1:0]      irq_stat,
  input  logic [NSLOT:0]       inserv,
  input  logic                 ctl_we,
  input  logic                 adr_we,
  input  logic [$clog2(NSLOT)-1:0] wr_idx,
  input  logic [DW-1:0]        wdata,
  input  logic                 rd_en,
  input  logic [$clog2(NSLOT)-1:0] rd_idx,
  output logic [DW-1:0]        ctl_rd,
  output logic [DW-1:0]        adr_q,
  output logic                 win_valid,
  output logic [$clog2(NSLOT)-1:0] win_idx,
  output logic                 nv_pend
);
  localparam int SW   = $clog2(NSLOT);
  localparam int SRCW = $clog2(NSRC);

  logic [NSLOT-1:0] s_en;
  logic [SRCW-1:0]  s_src [NSLOT];
  logic [DW-1:0]    s_adr [NSLOT];
  logic [NSLOT-1:0] hit, blk, elig;
  logic [NSRC-1:0]  claim;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_en <= '0;
      for (int n = 0; n < NSLOT; n++) s_src[n] <= '0;
    end else if (ctl_we) begin
      s_en[wr_idx]  <= wdata[CTL_EN_BIT];
      s_src[wr_idx] <= wdata[SRCW-1:0];
    end
  end

  // handler addresses: one write port, one registered read port
  always_ff @(posedge clk) begin
    if (adr_we) s_adr[wr_idx] <= wdata;
    if (rd_en)  adr_q <= s_adr[rd_idx];
  end

  for (genvar g = 0; g < NSLOT; g++) begin : g_hit
    assign hit[g] = s_en[g] & irq_stat[s_src[g]];
  end

  always_comb begin
    claim = '0;
    for (int n = 0; n < NSLOT; n++)
      if (s_en[n]) claim[s_src[n]] = 1'b1;
  end

  // a slot is blocked by its own level or any more urgent one in service
  always_comb begin
    blk[0] = inserv[0];
    for (int n = 1; n < NSLOT; n++) blk[n] = blk[n-1] | inserv[n];
    elig = hit & ~blk;
  end

  always_comb begin
    win_valid = |elig;
    win_idx   = '0;
    for (int n = NSLOT - 1; n >= 0; n--)
      if (elig[n]) win_idx = SW'(n);
  end

  assign nv_pend = |(irq_stat & ~claim);

  always_comb begin
    ctl_rd             = '0;
    ctl_rd[CTL_EN_BIT] = s_en[rd_idx];
    ctl_rd[SRCW-1:0]   = s_src[rd_idx];
  end
endmodule

// File: rtl/vic_nest.sv
module vic_nest #(
  parameter int NSLOT = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push,
  input  logic [$clog2(NSLOT+1)-1:0] push_lvl,
  input  logic                       pop,
  output logic [NSLOT:0]             inserv
);
  // levels only ever enter above the current top, so the mask is a stack
  // whose top is its lowest set bit
  always_ff @(posedge clk) begin
    if (rst)        inserv <= '0;
    else if (pop)   inserv <= inserv & (inserv - 1'b1);
    else if (push)  inserv[push_lvl] <= 1'b1;
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   src_i,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic              irq_o,
  output logic              fiq_o
);
  localparam int         SW   = $clog2(NSLOT);
  localparam int         LVW  = $clog2(NSLOT + 1);
  localparam logic [4:0] NSL5 = 5'(NSLOT);

  logic rd, vec_rd, ack_we, in_ctl, in_adr;
  logic [SW-1:0] idx, rd_idx, win_idx;
  logic [NSRC-1:0] en_q, frc_q, cls_q, raw, irq_stat, fiq_stat;
  logic [NSLOT:0] inserv;
  logic [DW-1:0] ctl_rd, adr_q, def_q, rd_val, reg_q;
  logic win_valid, nv_pend, def_elig, push, rsel_q;
  logic [LVW-1:0] push_lvl;

  assign rd     = bus_rd & ~bus_wr;
  assign in_ctl = (bus_addr[5:4] == RG_SLOT_CTL) && ({1'b0, bus_addr[3:0]} < NSL5);
  assign in_adr = (bus_addr[5:4] == RG_SLOT_ADR) && ({1'b0, bus_addr[3:0]} < NSL5);
  assign idx    = bus_addr[SW-1:0];
  assign vec_rd = rd && (bus_addr == A_VEC);
  assign ack_we = bus_wr && (bus_addr == A_VEC);

  vic_src #(.NSRC(NSRC)) u_src (
    .clk(clk), .rst(rst), .src_i(src_i), .wdata(bus_wdata[NSRC-1:0]),
    .en_set(bus_wr && bus_addr == A_EN_SET),
    .en_clr(bus_wr && bus_addr == A_EN_CLR),
    .frc_set(bus_wr && bus_addr == A_FRC_SET),
    .frc_clr(bus_wr && bus_addr == A_FRC_CLR),
    .cls_we(bus_wr && bus_addr == A_CLASS),
    .en_q(en_q), .frc_q(frc_q), .cls_q(cls_q),
    .raw(raw), .irq_stat(irq_stat), .fiq_stat(fiq_stat)
  );

  assign rd_idx = vec_rd ? win_idx : idx;

  vic_slots #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_slots (
    .clk(clk), .rst(rst), .irq_stat(irq_stat), .inserv(inserv),
    .ctl_we(bus_wr && in_ctl), .adr_we(bus_wr && in_adr),
    .wr_idx(idx), .wdata(bus_wdata),
    .rd_en(rd && (vec_rd || in_adr)), .rd_idx(rd_idx),
    .ctl_rd(ctl_rd), .adr_q(adr_q),
    .win_valid(win_valid), .win_idx(win_idx), .nv_pend(nv_pend)
  );

  assign def_elig = nv_pend && (inserv == '0);
  assign push     = vec_rd && (win_valid || def_elig);
  assign push_lvl = win_valid ? LVW'(win_idx) : LVW'(NSLOT);

  vic_nest #(.NSLOT(NSLOT)) u_nest (
    .clk(clk), .rst(rst), .push(push), .push_lvl(push_lvl),
    .pop(ack_we), .inserv(inserv)
  );

  always_ff @(posedge clk) begin
    if (rst) def_q <= '0;
    else if (bus_wr && bus_addr == A_DEF) def_q <= bus_wdata;
  end

  always_comb begin
    rd_val = '0;
    case (bus_addr)
      A_IRQ_STAT: rd_val[NSRC-1:0] = irq_stat;
      A_FIQ_STAT: rd_val[NSRC-1:0] = fiq_stat;
      A_RAW_STAT: rd_val[NSRC-1:0] = raw;
      A_CLASS:    rd_val[NSRC-1:0] = cls_q;
      A_EN_SET:   rd_val[NSRC-1:0] = en_q;
      A_FRC_SET:  rd_val[NSRC-1:0] = frc_q;
      A_VEC:      rd_val = def_q;
      A_DEF:      rd_val = def_q;
      default:    if (in_ctl) rd_val = ctl_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel_q <= 1'b0;
      reg_q  <= '0;
      irq_o  <= 1'b0;
      fiq_o  <= 1'b0;
    end else begin
      if (rd) begin
        rsel_q <= (vec_rd && win_valid) || in_adr;
        reg_q  <= rd_val;
      end
      irq_o <= win_valid || def_elig;
      fiq_o <= |fiq_stat;
    end
  end

  assign bus_rdata = rsel_q ? adr_q : reg_q;
endmodule

// File: rtl/vic_ctrl_chk.sv
module vic_ctrl_chk #(
  parameter int NSRC  = 32,
  parameter int NSLOT = 16
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     irq_o,
  input logic                     fiq_o,
  input logic [NSRC-1:0]          irq_stat,
  input logic [NSRC-1:0]          fiq_stat,
  input logic [NSLOT:0]           inserv,
  input logic                     ack_we,
  input logic                     vec_rd,
  input logic                     win_valid,
  input logic [$clog2(NSLOT)-1:0] win_idx
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && !fiq_o && inserv == '0));

  // R4
  fiq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (fiq_o == $past(|fiq_stat)));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(|irq_stat)) |-> !irq_o);

  // R8
  push_level_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_rd && win_valid) |=> inserv[$past(win_idx)]);

  // R9
  pop_one_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_we && inserv != '0) |=> ($countones(inserv) == $countones($past(inserv)) - 1));
endmodule

bind vic_ctrl vic_ctrl_chk #(.NSRC(NSRC), .NSLOT(NSLOT)) u_chk (
  .clk(clk), .rst(rst), .irq_o(irq_o), .fiq_o(fiq_o),
  .irq_stat(irq_stat), .fiq_stat(fiq_stat), .inserv(inserv),
  .ack_we(ack_we), .vec_rd(vec_rd), .win_valid(win_valid), .win_idx(win_idx)
);

// File: tb/vic_ctrl_bench.sv
module vic_ctrl_bench;
  localparam int NSRC = 8, NSLOT = 4, DW = 32;

  logic clk = 1'b0, rst = 1'b1;
  logic [NSRC-1:0] src_i = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0, bus_rdata;
  logic irq_o, fiq_o;

  int total = 0, bad = 0;
  bit done = 0;

  logic [7:0]  sl_src [NSLOT];
  logic [31:0] sl_adr [NSLOT];
  logic [NSLOT-1:0] sl_en;
  logic [31:0] defv;
  logic [31:0] r;

  always #2.5 clk = ~clk;

  vic_ctrl #(.NSRC(NSRC), .NSLOT(NSLOT), .DW(DW)) u_vic_ctrl (
    .clk(clk), .rst(rst), .src_i(src_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_vec(input int s);
    for (int k = 0; k < NSLOT; k++)
      if (sl_en[k] && sl_src[k] == s[7:0]) return sl_adr[k];
    return defv;
  endfunction

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs held low during reset
    chk("R1 irq in reset", {31'd0, irq_o}, 32'd0);
    chk("R1 fiq in reset", {31'd0, fiq_o}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R1 fiq after reset", {31'd0, fiq_o}, 32'd0);
    rd(6'h04, r); chk("R1 enables cleared", r, 32'd0);
    rd(6'h06, r); chk("R1 forces cleared", r, 32'd0);
    rd(6'h03, r); chk("R1 class cleared", r, 32'd0);
    rd(6'h10, r); chk("R1 slot ctl cleared", r, 32'd0);
    // R7: nothing pending -> default (0 after reset), no level entered
    rd(6'h08, r); chk("R7 idle vector read", r, 32'd0);

    // R2: single force bits, then mixed line/force patterns
    for (int s = 0; s < NSRC; s++) begin
      wr(6'h06, 32'(1 << s));
      rd(6'h02, r); chk("R2 forced raw", r, 32'(1 << s));
      wr(6'h07, 32'(1 << s));
      rd(6'h06, r); chk("R2 force cleared", r, 32'd0);
    end
    for (int p = 0; p < 16; p++) begin
      logic [7:0] f, h;
      f = 8'((p * 77 + 1) & 8'hFF);
      h = 8'((p * 29 + 3) & 8'hFF);
      wr(6'h07, 32'hFF);
      wr(6'h06, {24'd0, f});
      src_i = h;
      settle();
      rd(6'h02, r); chk("R2 raw mix", r, {24'd0, f | h});
    end
    wr(6'h07, 32'hFF);
    src_i = '0;

    // R3: set/clear affect only the written ones
    for (int s = 0; s < NSRC; s++) begin
      wr(6'h04, 32'(1 << s));
      rd(6'h04, r); chk("R3 enable set accum", r, 32'((1 << (s + 1)) - 1));
    end
    wr(6'h05, 32'h55);
    rd(6'h04, r); chk("R3 enable clear partial", r, 32'hAA);
    wr(6'h05, 32'hFF);

    // R3/R4/R8: status masks and outputs under many patterns (no slots yet)
    for (int i = 0; i < 24; i++) begin
      logic [7:0] e, c, h, ei, ef;
      e = 8'((i * 53 + 7) & 8'hFF);
      c = 8'((i * 91 + 3) & 8'hFF);
      h = 8'((i * 37 + 11) & 8'hFF);
      wr(6'h05, 32'hFF);
      wr(6'h04, {24'd0, e});
      wr(6'h03, {24'd0, c});
      src_i = h;
      settle();
      ei = h & e & ~c;
      ef = h & e & c;
      rd(6'h00, r); chk("R3 irq status", r, {24'd0, ei});
      rd(6'h01, r); chk("R3 fiq status", r, {24'd0, ef});
      rd(6'h03, r); chk("R3 class readback", r, {24'd0, c});
      chk("R4 fiq_o", {31'd0, fiq_o}, {31'd0, |ef});
      chk("R8 irq_o default only", {31'd0, irq_o}, {31'd0, |ei});
    end
    src_i = '0;
    wr(6'h03, 32'h0);
    wr(6'h04, 32'hFF);

    // R5: slot programming and readback
    defv = 32'hD000_0000;
    wr(6'h09, defv);
    rd(6'h09, r); chk("R7 default readback", r, defv);
    for (int k = 0; k < NSLOT; k++) begin
      sl_src[k] = 8'((k * 3 + 1) & 7);
      sl_adr[k] = 32'h1000_0000 + 32'(k * 64);
      sl_en[k]  = 1'b1;
      wr(6'(16 + k), 32'h100 | 32'(sl_src[k]));
      wr(6'(32 + k), sl_adr[k]);
    end
    for (int k = 0; k < NSLOT; k++) begin
      rd(6'(16 + k), r); chk("R5 slot ctl readback", r, 32'h100 | 32'(sl_src[k]));
      rd(6'(32 + k), r); chk("R5 slot addr readback", r, sl_adr[k]);
    end

    // R6/R7/R8: each source alone
    for (int s = 0; s < NSRC; s++) begin
      wr(6'h06, 32'(1 << s));
      settle();
      chk("R8 irq_o pending", {31'd0, irq_o}, 32'd1);
      rd(6'h08, r); chk("R6 R7 single source vector", r, exp_vec(s));
      wr(6'h07, 32'(1 << s));
      wr(6'h08, 32'd0);
      settle();
      chk("R9 irq_o after ack", {31'd0, irq_o}, 32'd0);
    end

    // R7: disabling a slot turns its source into a default one
    sl_en[1] = 1'b0;
    wr(6'h11, 32'(sl_src[1]));
    wr(6'h06, 32'(1 << sl_src[1]));
    settle();
    rd(6'h08, r); chk("R7 unclaimed after slot off", r, defv);
    wr(6'h07, 32'hFF); wr(6'h08, 32'd0);
    sl_en[1] = 1'b1;
    wr(6'h11, 32'h100 | 32'(sl_src[1]));

    // R8/R9/R10: nesting; sources slot0=1 slot1=4 slot2=7 slot3=2, unclaimed 5
    wr(6'h06, 32'(1 << 7));
    settle();
    rd(6'h08, r); chk("R6 slot2 first", r, sl_adr[2]);
    settle();
    chk("R8 own level blocked", {31'd0, irq_o}, 32'd0);
    wr(6'h06, 32'(1 << 2));
    settle();
    chk("R8 lower slot blocked", {31'd0, irq_o}, 32'd0);
    wr(6'h06, 32'(1 << 5));
    settle();
    chk("R10 default blocked", {31'd0, irq_o}, 32'd0);
    wr(6'h03, 32'h40); wr(6'h06, 32'h40);
    settle();
    chk("R4 fiq during service", {31'd0, fiq_o}, 32'd1);
    wr(6'h07, 32'h40); wr(6'h03, 32'h0);
    wr(6'h06, 32'(1 << 1));
    settle();
    chk("R9 higher nests", {31'd0, irq_o}, 32'd1);
    rd(6'h08, r); chk("R9 slot0 nested", r, sl_adr[0]);
    wr(6'h07, 32'(1 << 1));
    wr(6'h08, 32'd0);
    settle();
    chk("R9 one level popped", {31'd0, irq_o}, 32'd0);
    wr(6'h08, 32'd0);
    settle();
    chk("R9 second pop frees", {31'd0, irq_o}, 32'd1);
    rd(6'h08, r); chk("R9 slot2 again", r, sl_adr[2]);
    wr(6'h07, 32'(1 << 7)); wr(6'h08, 32'd0);
    rd(6'h08, r); chk("R6 slot3 next", r, sl_adr[3]);
    wr(6'h07, 32'(1 << 2)); wr(6'h08, 32'd0);
    rd(6'h08, r); chk("R10 default last", r, defv);
    wr(6'h07, 32'(1 << 5)); wr(6'h08, 32'd0);
    settle();
    chk("R8 idle at end", {31'd0, irq_o}, 32'd0);

    done = 1;
    finish_run();
  end
endmodule